// File: doc/BRIEF.md
# SPI Controller with Multi-Master Collision Detection

The block is an 8-bit SPI port that works either as the clock-driving master or as a selected slave. Software drives it through a control word, a byte data path and a transfer-complete flag. The control word sets the role, the SCK idle level, the sampling edge, the bit order, the master clock rate, the select-pin direction and level, the MISO drive permission and the interrupt enable. Each pin has a separate output value and output-enable, so the pads stay outside the block.

In master mode a byte written to the data path starts a transfer. The block drives SCK from a power-of-two divider of the system clock, shifts the byte out on MOSI and captures MISO into a receive holding register. In slave mode the block synchronises the external SCK, MOSI and select. It shifts while the select pin is low and holds its shift logic in reset while the select pin is high.

When the block is master and its select pin is an input, a low level on that pin means another master has taken the bus. The block then clears its own master bit, releases SCK and MOSI, and raises the flag. It stays a slave until software sets the master bit again.

Top module: `spi_node`

## Requirements
- R1: After reset the control word reads 0. The flag, irq and every output-enable are 0, and sck_o is 0.
- R2: In master mode, a data write while idle produces 8 SCK periods. Each SCK half period lasts 2, 8, 32 or 64 system clocks for rate field ctl[1:0] = 0, 1, 2 or 3. Before and after a transfer SCK rests at the CPOL bit ctl[3].
- R3: The phase bit ctl[2] selects the edges. With ctl[2]=0, data is sampled on the leading SCK edge and changes on the trailing edge. With ctl[2]=1, data changes on the leading edge and is sampled on the trailing edge. In master mode the byte sampled from miso_i appears on data_rdata when the flag rises.
- R4: Order bit ctl[4]=0 shifts MSB first and ctl[4]=1 shifts LSB first, for both the transmitted and the received byte.
- R5: The flag sets in the cycle after the 8th sampling edge. A status read while the flag is set, followed by a data read or a data write, clears it.
- R6: irq is high only when the flag, the interrupt-enable bit ctl[7] and the gie input are all 1.
- R7: Master bit ctl[5]=1 with select direction ctl[6]=0 and a low synchronised ss_i is a collision. The block then clears ctl[5], drops sck_oe and mosi_oe, and sets the flag.
- R8: After a collision ctl[5] stays 0 until a control write sets it again. A later high level on ss_i does not restore it.
- R9: In master mode with ctl[6]=1, ss_oe is 1 and ss_o follows ctl[8]. A low ss_i then causes no collision, and transfers complete normally.
- R10: In slave mode sck_oe, mosi_oe and ss_oe are 0. miso_oe is 1 only while the select pin is low and the MISO drive bit ctl[9] is 1.
- R11: In slave mode with the select pin low, the block receives 8 MOSI bits into data_rdata. It sends the last written data byte on miso_o and sets the flag.
- R12: If the select pin rises during a slave transfer, the transfer is discarded and the flag is not set. The next selection starts a fresh transfer with the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 10 | Control word to write |
| ctl_rdata | output | 10 | Current control word (master bit live) |
| stat_rd | input | 1 | Status read strobe |
| stat_flag | output | 1 | Transfer-complete / collision flag |
| data_we | input | 1 | Data write strobe (starts a master transfer) |
| data_wdata | input | 8 | Byte to transmit |
| data_rd | input | 1 | Data read strobe |
| data_rdata | output | 8 | Receive holding register |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | SCK pad input |
| sck_o | output | 1 | SCK output value |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pad input |
| mosi_o | output | 1 | MOSI output value |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pad input |
| miso_o | output | 1 | MISO output value |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | Select pad input |
| ss_o | output | 1 | Select output value |
| ss_oe | output | 1 | Select output enable |

## Verification
Master transfers cover all four polarity and phase combinations, both bit orders and all four rates. The bytes are asymmetric, so a reversed order or a one-bit slip gives a different result, and the measured half period distinguishes the rate codes. Slave transfers use the same asymmetric patterns against a bench-driven SCK to separate leading-edge from trailing-edge sampling. A slave transfer cut off after four bits checks that no flag appears and that the next transfer starts clean. A collision raised mid-transfer checks the role change, the released pins, the flag and irq gating, and that master mode does not return until software writes it.

// File: rtl/spi_node_pkg.sv
package spi_node_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CTL_W  = 10;
  localparam int unsigned DIV_W  = 7;
  localparam int unsigned EDGES  = 2 * DATA_W;

  // control word field positions
  localparam int unsigned B_RATE  = 0;  // two bits
  localparam int unsigned B_CPHA  = 2;
  localparam int unsigned B_CPOL  = 3;
  localparam int unsigned B_LSB   = 4;
  localparam int unsigned B_MSTR  = 5;
  localparam int unsigned B_SSOUT = 6;
  localparam int unsigned B_IRQEN = 7;
  localparam int unsigned B_SSLVL = 8;
  localparam int unsigned B_MISO  = 9;

  // system clocks per SCK half period for each rate code
  function automatic logic [DIV_W-1:0] half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    return DIV_W'(2);
      2'd1:    return DIV_W'(8);
      2'd2:    return DIV_W'(32);
      default: return DIV_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/spi_node_sckgen.sv
module spi_node_sckgen
  import spi_node_pkg::*;
#(
  parameter int unsigned N_EDGES = EDGES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       cpol,
  input  logic [1:0] rate,
  output logic       sck,
  output logic       lead,
  output logic       trail,
  output logic       busy
);
  localparam int unsigned EW = $clog2(N_EDGES);

  logic [DIV_W-1:0] div_q;
  logic [EW-1:0]    edge_q;
  logic             phase_q;
  logic             busy_q;
  logic             tick;

  assign tick = busy_q && (div_q == half_period(rate) - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (abort) begin
      div_q   <= '0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (start && !busy_q) begin
      div_q   <= '0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      busy_q  <= 1'b1;
    end else if (tick) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
      edge_q  <= edge_q + EW'(1);
      if (edge_q == EW'(N_EDGES - 1)) busy_q <= 1'b0;
    end else if (busy_q) begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  assign lead  = tick && !edge_q[0];
  assign trail = tick && edge_q[0];
  assign sck   = cpol ^ phase_q;
  assign busy  = busy_q;
endmodule

// File: rtl/spi_node_shift.sv
module spi_node_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lead,
  input  logic         trail,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         sdi,
  output logic         sdo,
  output logic [W-1:0] rx,
  output logic         done
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  tx_q;
  logic [W-1:0]  rx_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          sample_e;
  logic          shift_e;

  assign sample_e = cpha ? trail : lead;
  assign shift_e  = cpha ? lead  : trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        tx_q  <= load_data;
        cnt_q <= '0;
      end else begin
        if (sample_e) begin
          rx_q <= lsb_first ? {sdi, rx_q[W-1:1]} : {rx_q[W-2:0], sdi};
          if (cnt_q == CW'(W - 1)) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        if (shift_e && cnt_q != '0)
          tx_q <= lsb_first ? {1'b0, tx_q[W-1:1]} : {tx_q[W-2:0], 1'b0};
      end
    end
  end

  assign sdo  = lsb_first ? tx_q[0] : tx_q[W-1];
  assign rx   = rx_q;
  assign done = done_q;
endmodule

// File: rtl/spi_node.sv
module spi_node
  import spi_node_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             stat_rd,
  output logic             stat_flag,
  input  logic             data_we,
  input  logic [W-1:0]     data_wdata,
  input  logic             data_rd,
  output logic [W-1:0]     data_rdata,
  input  logic             gie,
  output logic             irq,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             ss_i,
  output logic             ss_o,
  output logic             ss_oe
);
  logic [CTL_W-1:0] ctl_q;
  logic             flag_q, armed_q;
  logic [W-1:0]     tx_hold, rx_hold;
  logic [2:0]       sck_sy;
  logic [1:0]       ss_sy, mosi_sy;

  // named internal events
  logic ss_sync, is_master, mode_fault, m_start, slave_sel;
  logic s_rise, s_fall, s_lead, s_trail;
  logic m_lead, m_trail, m_busy, m_sck;
  logic sh_load, sh_lead, sh_trail, sh_sdi, sh_sdo, xfer_done;
  logic [W-1:0] sh_data, sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      ss_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck_i};
      ss_sy   <= {ss_sy[0], ss_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
    end
  end

  assign ss_sync    = ss_sy[1];
  assign is_master  = ctl_q[B_MSTR];
  assign mode_fault = is_master && !ctl_q[B_SSOUT] && !ss_sync;
  assign m_start    = data_we && is_master && !m_busy && !mode_fault;
  assign slave_sel  = !is_master && !ss_sync;
  assign s_rise     = sck_sy[1] && !sck_sy[2];
  assign s_fall     = !sck_sy[1] && sck_sy[2];
  assign s_lead     = slave_sel && (ctl_q[B_CPOL] ? s_fall : s_rise);
  assign s_trail    = slave_sel && (ctl_q[B_CPOL] ? s_rise : s_fall);

  spi_node_sckgen #(.N_EDGES(2 * W)) u_sckgen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (m_start),
    .abort (mode_fault || !is_master),
    .cpol  (ctl_q[B_CPOL]),
    .rate  (ctl_q[B_RATE +: 2]),
    .sck   (m_sck),
    .lead  (m_lead),
    .trail (m_trail),
    .busy  (m_busy)
  );

  assign sh_load  = m_start || mode_fault || (!is_master && ss_sync);
  assign sh_data  = m_start ? data_wdata : tx_hold;
  assign sh_lead  = is_master ? m_lead  : s_lead;
  assign sh_trail = is_master ? m_trail : s_trail;
  assign sh_sdi   = is_master ? miso_i  : mosi_sy[1];

  spi_node_shift #(.W(W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sh_load),
    .load_data (sh_data),
    .lead      (sh_lead),
    .trail     (sh_trail),
    .cpha      (ctl_q[B_CPHA]),
    .lsb_first (ctl_q[B_LSB]),
    .sdi       (sh_sdi),
    .sdo       (sh_sdo),
    .rx        (sh_rx),
    .done      (xfer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      tx_hold <= '0;
      rx_hold <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (mode_fault)  ctl_q[B_MSTR] <= 1'b0;
      else if (ctl_we) ctl_q <= ctl_wdata;
      if (data_we)   tx_hold <= data_wdata;
      if (xfer_done) rx_hold <= sh_rx;
      if (xfer_done || mode_fault) begin
        flag_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (armed_q && (data_we || data_rd)) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (stat_rd && flag_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign ctl_rdata  = ctl_q;
  assign stat_flag  = flag_q;
  assign data_rdata = rx_hold;
  assign irq        = flag_q && ctl_q[B_IRQEN] && gie;

  assign sck_o   = m_sck;
  assign sck_oe  = is_master;
  assign mosi_o  = sh_sdo;
  assign mosi_oe = is_master;
  assign miso_o  = sh_sdo;
  assign miso_oe = slave_sel && ctl_q[B_MISO];
  assign ss_o    = ctl_q[B_SSLVL];
  assign ss_oe   = is_master && ctl_q[B_SSOUT];
endmodule

// File: rtl/spi_node_chk.sv
module spi_node_chk
  import spi_node_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             stat_flag,
  input logic             gie,
  input logic             irq,
  input logic             sck_o,
  input logic             sck_oe,
  input logic             mosi_oe,
  input logic             miso_oe,
  input logic             ss_oe,
  input logic             mode_fault,
  input logic             xfer_done,
  input logic             ss_sync,
  input logic             m_busy
);
  AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> (!ctl_rdata[B_MSTR] && !sck_oe && !mosi_oe && stat_flag)); // R7
  AST_NO_AUTO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[B_MSTR] && !ctl_we) |=> !ctl_rdata[B_MSTR]); // R8
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> stat_flag); // R5
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !m_busy |-> (sck_o == ctl_rdata[B_CPOL])); // R2
  AST_SLAVE_PINS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[B_MSTR] |-> (!sck_oe && !mosi_oe && !ss_oe)); // R10
  AST_MISO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !(sck_oe || mosi_oe)); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_flag && gie)); // R6
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ss_sync) && !ctl_rdata[B_MSTR]) |=> !xfer_done); // R12
endmodule

bind spi_node spi_node_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_we     (ctl_we),
  .ctl_rdata  (ctl_rdata),
  .stat_flag  (stat_flag),
  .gie        (gie),
  .irq        (irq),
  .sck_o      (sck_o),
  .sck_oe     (sck_oe),
  .mosi_oe    (mosi_oe),
  .miso_oe    (miso_oe),
  .ss_oe      (ss_oe),
  .mode_fault (mode_fault),
  .xfer_done  (xfer_done),
  .ss_sync    (ss_sync),
  .m_busy     (m_busy)
);

// File: tb/spi_node_test.sv
module spi_node_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [9:0] ctl_wdata = '0;
  logic [9:0] ctl_rdata;
  logic       stat_rd = 1'b0, stat_flag;
  logic       data_we = 1'b0, data_rd = 1'b0;
  logic [7:0] data_wdata = '0, data_rdata;
  logic       gie = 1'b0, irq;
  logic       sck_i = 1'b0, sck_o, sck_oe;
  logic       mosi_i = 1'b0, mosi_o, mosi_oe;
  logic       miso_i = 1'b0, miso_o, miso_oe;
  logic       ss_i = 1'b1, ss_o, ss_oe;

  int vectors = 0;
  int misses = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       flag_prev = 1'b0;

  localparam int SHP = 10;  // slave-side SCK half period in clocks

  always #10 clk = ~clk;

  spi_node uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .stat_rd(stat_rd), .stat_flag(stat_flag), .data_we(data_we), .data_wdata(data_wdata),
    .data_rd(data_rd), .data_rdata(data_rdata), .gie(gie), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] cw(input logic [1:0] rate, input logic cpha, input logic cpol,
                                    input logic lsb, input logic mstr, input logic ssout,
                                    input logic irqen, input logic sslvl, input logic misod);
    return {misod, sslvl, irqen, ssout, mstr, lsb, cpol, cpha, rate};
  endfunction

  function automatic int bidx(input int b, input logic lsb);
    return lsb ? b : 7 - b;
  endfunction

  task automatic wr_ctl(input logic [9:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    @(negedge clk);
    check(!stat_flag, "R5 flag cleared by status read then data access", stat_flag, 0);
  endtask

  task automatic wait_flag();
    while (!stat_flag) @(negedge clk);
  endtask

  // monitor: compare the receive register when the flag rises
  always @(negedge clk) begin
    if (stat_flag && !flag_prev && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(data_rdata == e, t, data_rdata, e);
    end
    flag_prev = stat_flag;
  end

  // driver: the bench plays the slave while the design is master
  task automatic master_xfer(input logic [1:0] rate, input logic cpol, input logic cpha,
                             input logic lsb, input logic ssout, input logic [7:0] tx,
                             input logic [7:0] slv);
    logic [7:0] got;
    time t0;
    int hp;
    got = '0;
    t0 = 0;
    hp = (rate == 2'd0) ? 2 : (rate == 2'd1) ? 8 : (rate == 2'd2) ? 32 : 64;
    wr_ctl(cw(rate, cpha, cpol, lsb, 1'b1, ssout, 1'b0, 1'b1, 1'b0));
    miso_i = slv[bidx(0, lsb)];
    exp_q.push_back(slv);
    tag_q.push_back("R3 R4 master receive byte");
    wr_data(tx);
    for (int e = 0; e < 16; e++) begin
      int  bi;
      logic samp;
      @(sck_o); #1;
      if (e == 0) t0 = $time;
      if (e == 1) check(($time - t0) == time'(hp * 20), "R2 SCK half period", int'($time - t0), hp * 20);
      bi = e / 2;
      samp = cpha ? (e % 2 == 1) : (e % 2 == 0);
      if (samp) got[bidx(bi, lsb)] = mosi_o;
      else if (cpha) miso_i = slv[bidx(bi, lsb)];
      else if (bi < 7) miso_i = slv[bidx(bi + 1, lsb)];
    end
    wait_flag();
    check(got == tx, "R3 R4 master transmit byte", got, tx);
    @(negedge clk);
    check(sck_o == cpol, "R2 SCK rests at CPOL", sck_o, cpol);
    check(ctl_rdata[5] && sck_oe && mosi_oe, "R9 master kept", {ctl_rdata[5], sck_oe, mosi_oe}, 3'b111);
    clear_flag();
  endtask

  // driver: the bench plays the master while the design is slave
  task automatic slave_xfer(input logic cpol, input logic cpha, input logic lsb,
                            input logic [7:0] mo, input logic [7:0] txb, input int nbits);
    logic [7:0] got;
    got = '0;
    wr_ctl(cw(2'd0, cpha, cpol, lsb, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    sck_i = cpol;
    wr_data(txb);
    repeat (4) @(negedge clk);
    check(!miso_oe && !sck_oe && !mosi_oe && !ss_oe, "R10 passive slave drives nothing",
          {miso_oe, sck_oe, mosi_oe, ss_oe}, 0);
    ss_i = 1'b0;
    repeat (4) @(negedge clk);
    check(miso_oe && !sck_oe && !mosi_oe, "R10 selected slave drives only MISO",
          {miso_oe, sck_oe, mosi_oe}, 3'b100);
    if (nbits == 8) begin
      exp_q.push_back(mo);
      tag_q.push_back("R11 slave receive byte");
    end
    for (int bi = 0; bi < nbits; bi++) begin
      if (!cpha) begin
        mosi_i = mo[bidx(bi, lsb)];
        repeat (SHP) @(negedge clk);
        got[bidx(bi, lsb)] = miso_o;
        sck_i = ~sck_i;
        repeat (SHP) @(negedge clk);
        sck_i = ~sck_i;
      end else begin
        sck_i = ~sck_i;
        mosi_i = mo[bidx(bi, lsb)];
        repeat (SHP) @(negedge clk);
        got[bidx(bi, lsb)] = miso_o;
        sck_i = ~sck_i;
        repeat (SHP) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    if (nbits == 8) begin
      check(stat_flag, "R11 slave flag after 8 bits", stat_flag, 1);
      check(got == txb, "R11 slave MISO byte", got, txb);
      ss_i = 1'b1;
      repeat (4) @(negedge clk);
      clear_flag();
    end else begin
      ss_i = 1'b1;
      repeat (8) @(negedge clk);
      check(!stat_flag, "R12 aborted slave transfer raises no flag", stat_flag, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ctl_rdata == 10'd0 && !stat_flag && !irq, "R1 reset registers",
          {ctl_rdata, stat_flag, irq}, 0);
    check(!sck_oe && !mosi_oe && !miso_oe && !ss_oe && !sck_o, "R1 reset pins",
          {sck_oe, mosi_oe, miso_oe, ss_oe, sck_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    master_xfer(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC5, 8'h3A);
    master_xfer(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h96, 8'h61);
    master_xfer(2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h1E, 8'hB4);
    master_xfer(2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h83, 8'h4D);
    master_xfer(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h07, 8'hE0);

    // R9: select as output, low ss_i causes no collision
    wr_ctl(cw(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
    ss_i = 1'b0;
    repeat (5) @(negedge clk);
    check(ss_oe && ss_o && ctl_rdata[5], "R9 select pin is an output", {ss_oe, ss_o, ctl_rdata[5]}, 3'b111);
    master_xfer(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5C, 8'hA3);
    ss_i = 1'b1;

    // slave transfers in all modes, both orders
    slave_xfer(1'b0, 1'b0, 1'b0, 8'hC6, 8'h2B, 8);
    slave_xfer(1'b0, 1'b1, 1'b1, 8'h39, 8'hD4, 8);
    slave_xfer(1'b1, 1'b0, 1'b1, 8'h71, 8'h8E, 8);
    slave_xfer(1'b1, 1'b1, 1'b0, 8'hE2, 8'h17, 8);

    // R12: abort after four bits, then a fresh full transfer
    slave_xfer(1'b0, 1'b1, 1'b0, 8'hF0, 8'hA5, 4);
    slave_xfer(1'b0, 1'b1, 1'b0, 8'h4B, 8'hA5, 8);

    // R7 / R6 / R8: collision during a master transfer
    gie = 1'b1;
    wr_ctl(cw(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
    wr_data(8'h99);
    repeat (20) @(negedge clk);
    ss_i = 1'b0;
    repeat (5) @(negedge clk);
    check(!ctl_rdata[5], "R7 master bit cleared on collision", ctl_rdata[5], 0);
    check(!sck_oe && !mosi_oe, "R7 SCK and MOSI released", {sck_oe, mosi_oe}, 0);
    check(stat_flag, "R7 flag set on collision", stat_flag, 1);
    check(irq, "R6 irq with flag, enable and gie", irq, 1);
    gie = 1'b0;
    @(negedge clk);
    check(!irq, "R6 irq masked by gie", irq, 0);
    gie = 1'b1;
    ss_i = 1'b1;
    repeat (40) @(negedge clk);
    check(!ctl_rdata[5] && !sck_oe, "R8 master stays off", {ctl_rdata[5], sck_oe}, 0);
    clear_flag();
    check(!irq, "R6 irq low after flag clear", irq, 0);
    wr_ctl(cw(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    check(ctl_rdata[5] && sck_oe && mosi_oe, "R8 master restored by write",
          {ctl_rdata[5], sck_oe, mosi_oe}, 3'b111);
    master_xfer(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h6D, 8'h92);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 R11 all expected bytes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule